// File: doc/BRIEF.md
# Multilinear GF(2^64) Line Tag Unit

This block produces a 56-bit integrity tag for one 512-bit memory line. The line is split into eight 64-bit words. Each word is multiplied by a 64-bit hash key of its own in the binary field GF(2^64). The eight products are combined with a 64-bit mask, and the result is cut down to 56 bits so that a tag is the same width as a version counter. The mask comes from outside the block. It is normally the low half of a block-cipher encryption of a nonce that this block builds from the line's version counter and its line address. The cipher itself is not part of this block.

A caller drives the operands and pulses `start_in`. The block then runs one field multiplication per clock, stepping through the words in order. A one-cycle `done_out` pulse presents the finished tag. In compare mode, the same pulse also reports whether the computed tag equals a tag the caller supplied, for example one read back from memory next to the line.

Top module: `mlmac_tag_unit`

## Requirements
- R1: Let word i of `line_in` be bits [64i+63:64i], and let key i of `hkey_in` be bits [64i+63:64i]. The full result is the XOR of `mask_in` with the eight field products word_i·key_i.
- R2: Field multiplication is carry-less polynomial multiplication reduced modulo x^64 + x^4 + x^3 + x + 1 (low coefficient word 64'h1B).
- R3: `tag_out` is bits [55:0] of the full 64-bit result. Bits [63:56] are dropped.
- R4: `nonce_out` is combinational from the current inputs: bits [127:72] hold `ctr_in`, bits [71:39] hold `line_addr_in`, and bits [38:0] are zero.
- R5: When a start is accepted at a clock edge, `done_out` goes high for exactly one cycle after the 8th following edge. This gives one field multiplication per clock.
- R6: A `start_in` pulse while a computation is in progress is ignored. The running result uses only the operands captured at the accepted start, and the ignored pulse produces no extra `done_out`.
- R7: `cmp_mode_in` and `ref_tag_in` are captured at the accepted start. `match_out` is 1 at `done_out` only when compare mode was selected and the computed tag equals the captured reference tag. Otherwise it is 0.
- R8: While `rst_n` is low, `done_out`, `tag_out` and `match_out` are all zero.
- R9: `tag_out` and `match_out` change only in a cycle where `done_out` is high, and they hold their values until the next `done_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_in | input | 1 | Launch a tag computation (ignored while one runs) |
| cmp_mode_in | input | 1 | Select compare mode for this computation |
| line_in | input | 512 | Eight 64-bit data words |
| hkey_in | input | 512 | Eight 64-bit hash keys |
| mask_in | input | 64 | Additive mask (encrypted nonce, low half) |
| ref_tag_in | input | 56 | Stored tag to compare against |
| ctr_in | input | 56 | Version counter for the nonce |
| line_addr_in | input | 33 | Line address (byte address shifted right by 6) |
| nonce_out | output | 128 | Compound nonce for the external mask generator |
| done_out | output | 1 | One-cycle result pulse |
| tag_out | output | 56 | Truncated tag |
| match_out | output | 1 | Compare result |

## Verification
The assertions check timing and framing on every cycle:
- the word index stays in range while busy;
- `done_out` is a single-cycle pulse that coincides with the end of a run;
- captured operands do not move during a run;
- the result outputs change only on `done_out`.

The field arithmetic itself can only be shown by the bench scenarios. These are:
- a full sweep of single-bit operand pairs, which reaches every reduction path of the polynomial;
- pseudo-random full lines;
- all-zero and all-ones operands;
- truncation of the mask's top byte;
- matching and mismatching compare cases;
- a start pulse injected mid-run.

// File: rtl/mlmac_pkg.sv
package mlmac_pkg;

  localparam int unsigned DEF_WORDS  = 8;
  localparam int unsigned DEF_WORD_W = 64;
  localparam int unsigned DEF_TAG_W  = 56;
  localparam int unsigned DEF_CTR_W  = 56;
  localparam int unsigned DEF_ADDR_W = 33;

  // low coefficients of x^64 + x^4 + x^3 + x + 1
  localparam logic [63:0] DEF_POLY = 64'h0000_0000_0000_001B;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/mlmac_gfmul.sv
module mlmac_gfmul #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] POLY = 64'h1B
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] p_out
);

  localparam int unsigned WIDE = 2 * W - 1;

  // carry-less product of two W-bit polynomials
  function automatic logic [WIDE-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [WIDE-1:0] acc;
    logic [WIDE-1:0] a_ext;
    acc   = '0;
    a_ext = {{(W-1){1'b0}}, a};
    for (int i = 0; i < int'(W); i++) begin
      if (b[i]) acc = acc ^ (a_ext << i);
    end
    return acc;
  endfunction

  // fold the upper part back using the reduction polynomial, top bit first
  function automatic logic [W-1:0] fold(input logic [WIDE-1:0] wide);
    logic [WIDE-1:0] t;
    logic [WIDE-1:0] poly_ext;
    t        = wide;
    poly_ext = {{(W-2){1'b0}}, 1'b1, POLY};
    for (int i = int'(WIDE) - 1; i >= int'(W); i--) begin
      if (t[i]) t = t ^ (poly_ext << (i - int'(W)));
    end
    return t[W-1:0];
  endfunction

  logic [WIDE-1:0] raw_prod;

  always_comb begin
    raw_prod = clmul(a_in, b_in);
    p_out    = fold(raw_prod);
  end

endmodule

// File: rtl/mlmac_seq.sv
module mlmac_seq #(
  parameter int unsigned NWORDS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_in,
  output logic                      accept_o,
  output logic                      busy_o,
  output logic                      last_o,
  output logic [$clog2(NWORDS)-1:0] idx_o,
  output logic                      done_o
);
  import mlmac_pkg::*;

  localparam int unsigned IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign busy_o   = (state_q == SEQ_RUN);
  assign accept_o = start_in && !busy_o;
  assign last_o   = busy_o && (idx_q == LAST_IDX);
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        state_q <= SEQ_RUN;
        idx_q   <= '0;
      end else if (busy_o) begin
        if (last_o) begin
          state_q <= SEQ_IDLE;
          idx_q   <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(idx_q) < int'(NWORDS)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_run_ends_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_q);

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> busy_o);

endmodule

// File: rtl/mlmac_accum.sv
module mlmac_accum #(
  parameter int unsigned NWORDS = 8,
  parameter int unsigned W = 64,
  parameter logic [W-1:0] POLY = 64'h1B
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_in,
  input  logic                      step_in,
  input  logic [$clog2(NWORDS)-1:0] idx_in,
  input  logic [NWORDS*W-1:0]       line_in,
  input  logic [NWORDS*W-1:0]       key_in,
  input  logic [W-1:0]              mask_in,
  output logic [W-1:0]              full_o
);

  localparam int unsigned LINE_W = NWORDS * W;

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] key_q;
  logic [W-1:0]      mask_q;
  logic [W-1:0]      acc_q;
  logic [W-1:0]      q_words [NWORDS];
  logic [W-1:0]      k_words [NWORDS];
  logic [W-1:0]      q_sel;
  logic [W-1:0]      k_sel;
  logic [W-1:0]      prod;

  for (genvar g = 0; g < int'(NWORDS); g++) begin : g_unpack
    assign q_words[g] = line_q[g*W +: W];
    assign k_words[g] = key_q[g*W +: W];
  end

  assign q_sel = q_words[idx_in];
  assign k_sel = k_words[idx_in];

  mlmac_gfmul #(.W(W), .POLY(POLY)) u_mul (
    .a_in (q_sel),
    .b_in (k_sel),
    .p_out(prod)
  );

  // value after the current step: used by the top on the last word
  assign full_o = acc_q ^ prod ^ mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      key_q  <= '0;
      mask_q <= '0;
      acc_q  <= '0;
    end else if (load_in) begin
      line_q <= line_in;
      key_q  <= key_in;
      mask_q <= mask_in;
      acc_q  <= '0;
    end else if (step_in) begin
      acc_q <= acc_q ^ prod;
    end
  end

  assert_operands_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_in && !load_in) |=> ($stable(line_q) && $stable(key_q) && $stable(mask_q)));

  assert_load_not_while_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_in && step_in));

endmodule

// File: rtl/mlmac_tag_unit.sv
module mlmac_tag_unit #(
  parameter int unsigned NWORDS = mlmac_pkg::DEF_WORDS,
  parameter int unsigned WORD_W = mlmac_pkg::DEF_WORD_W,
  parameter int unsigned TAG_W  = mlmac_pkg::DEF_TAG_W,
  parameter int unsigned CTR_W  = mlmac_pkg::DEF_CTR_W,
  parameter int unsigned ADDR_W = mlmac_pkg::DEF_ADDR_W,
  parameter logic [WORD_W-1:0] POLY = mlmac_pkg::DEF_POLY
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_in,
  input  logic                       cmp_mode_in,
  input  logic [NWORDS*WORD_W-1:0]   line_in,
  input  logic [NWORDS*WORD_W-1:0]   hkey_in,
  input  logic [WORD_W-1:0]          mask_in,
  input  logic [TAG_W-1:0]           ref_tag_in,
  input  logic [CTR_W-1:0]           ctr_in,
  input  logic [ADDR_W-1:0]          line_addr_in,
  output logic [2*WORD_W-1:0]        nonce_out,
  output logic                       done_out,
  output logic [TAG_W-1:0]           tag_out,
  output logic                       match_out
);

  localparam int unsigned IDX_W   = $clog2(NWORDS);
  localparam int unsigned NONCE_W = 2 * WORD_W;
  localparam int unsigned PAD_W   = NONCE_W - CTR_W - ADDR_W;

  // named internal events
  logic              ev_accept;
  logic              ev_busy;
  logic              ev_last;
  logic              ev_done;
  logic [IDX_W-1:0]  word_idx;
  logic [WORD_W-1:0] full_word;
  logic [TAG_W-1:0]  trunc_tag;

  logic              cmp_q;
  logic [TAG_W-1:0]  ref_q;
  logic [TAG_W-1:0]  tag_q;
  logic              match_q;

  assign nonce_out = {ctr_in, line_addr_in, {PAD_W{1'b0}}};

  mlmac_seq #(.NWORDS(NWORDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_in(start_in),
    .accept_o(ev_accept),
    .busy_o  (ev_busy),
    .last_o  (ev_last),
    .idx_o   (word_idx),
    .done_o  (ev_done)
  );

  mlmac_accum #(.NWORDS(NWORDS), .W(WORD_W), .POLY(POLY)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_in(ev_accept),
    .step_in(ev_busy),
    .idx_in (word_idx),
    .line_in(line_in),
    .key_in (hkey_in),
    .mask_in(mask_in),
    .full_o (full_word)
  );

  assign trunc_tag = full_word[TAG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= 1'b0;
      ref_q   <= '0;
      tag_q   <= '0;
      match_q <= 1'b0;
    end else begin
      if (ev_accept) begin
        cmp_q <= cmp_mode_in;
        ref_q <= ref_tag_in;
      end
      if (ev_last) begin
        tag_q   <= trunc_tag;
        match_q <= cmp_q && (trunc_tag == ref_q);
      end
    end
  end

  assign done_out  = ev_done;
  assign tag_out   = tag_q;
  assign match_out = match_q;

  assert_tag_moves_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_out) |-> done_out);

  assert_match_moves_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(match_out) |-> done_out);

  assert_match_needs_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_out && match_out) |-> $past(cmp_q));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |-> !ev_busy);

endmodule

// File: tb/mlmac_tag_unit_test.sv
`timescale 1ns/1ps
module mlmac_tag_unit_test;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_in = 1'b0;
  logic          cmp_mode_in = 1'b0;
  logic [511:0]  line_in = '0;
  logic [511:0]  hkey_in = '0;
  logic [63:0]   mask_in = '0;
  logic [55:0]   ref_tag_in = '0;
  logic [55:0]   ctr_in = '0;
  logic [32:0]   line_addr_in = '0;
  logic [127:0]  nonce_out;
  logic          done_out;
  logic [55:0]   tag_out;
  logic          match_out;

  int vec_cnt = 0;
  int bad_cnt = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  mlmac_tag_unit uut (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .cmp_mode_in(cmp_mode_in),
    .line_in(line_in), .hkey_in(hkey_in), .mask_in(mask_in), .ref_tag_in(ref_tag_in),
    .ctr_in(ctr_in), .line_addr_in(line_addr_in), .nonce_out(nonce_out),
    .done_out(done_out), .tag_out(tag_out), .match_out(match_out)
  );

  // shift-and-reduce field product, high key bit first
  function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 63; i >= 0; i--) begin
      r = {r[62:0], 1'b0} ^ (r[63] ? 64'h1B : 64'h0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [55:0] ref_tag(input logic [511:0] q, input logic [511:0] k,
                                          input logic [63:0] m);
    logic [63:0] s = m;
    for (int w = 0; w < 8; w++) s = s ^ ref_mul(q[64*w +: 64], k[64*w +: 64]);
    return s[55:0];
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
  endtask

  // drive one computation; returns whether done arrived exactly 8 cycles later
  task automatic run_one(input logic [511:0] q, input logic [511:0] k, input logic [63:0] m,
                         input logic cmp, input logic [55:0] rt, output logic lat_ok);
    @(negedge clk);
    line_in = q; hkey_in = k; mask_in = m; cmp_mode_in = cmp; ref_tag_in = rt;
    start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    lat_ok = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (c < 8 && done_out) lat_ok = 1'b0;
      if (c == 8 && !done_out) lat_ok = 1'b0;
    end
  endtask

  task automatic rand_line(output logic [511:0] v);
    for (int w = 0; w < 8; w++) begin
      rng = next_rng(rng);
      v[64*w +: 64] = rng;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    bad_cnt++;
    summary();
    $finish;
  end

  initial begin
    logic lat;
    logic [511:0] q, k, q2;
    logic [63:0] m;
    logic [55:0] e;

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 done", done_out, 0);
    check("R8 tag", tag_out, 0);
    check("R8 match", match_out, 0);
    @(negedge clk); rst_n = 1'b1;

    // R4: nonce layout
    ctr_in = 56'hAB_CDEF_0123_4567; line_addr_in = 33'h1_2345_6789;
    #1 check("R4 nonce", nonce_out, {56'hAB_CDEF_0123_4567, 33'h1_2345_6789, 39'h0});
    ctr_in = '1; line_addr_in = '0;
    #1 check("R4 nonce ctr", nonce_out, {56'hFF_FFFF_FFFF_FFFF, 72'h0});
    ctr_in = '0; line_addr_in = '1;
    #1 check("R4 nonce addr", nonce_out, {56'h0, 33'h1_FFFF_FFFF, 39'h0});

    // R1 R2: sweep of single-bit operand pairs in word 0 (covers all reduction paths)
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        q = '0; k = '0;
        q[i] = 1'b1; k[j] = 1'b1;
        run_one(q, k, 64'h0, 1'b0, 56'h0, lat);
        check("R2 bit sweep", tag_out, ref_tag(q, k, 64'h0));
      end
    end

    // R1: each word position paired with its own key
    for (int w = 0; w < 8; w++) begin
      q = '0; k = '0;
      rng = next_rng(rng); q[64*w +: 64] = rng;
      rng = next_rng(rng); k[64*w +: 64] = rng;
      run_one(q, k, 64'h0, 1'b0, 56'h0, lat);
      check("R1 word position", tag_out, ref_tag(q, k, 64'h0));
    end

    // R1 R5: random full lines with masks, latency checked
    for (int n = 0; n < 40; n++) begin
      rand_line(q); rand_line(k);
      rng = next_rng(rng); m = rng;
      run_one(q, k, m, 1'b0, 56'h0, lat);
      check("R1 random line", tag_out, ref_tag(q, k, m));
      check("R5 latency", lat, 1'b1);
      @(negedge clk);
      check("R5 single pulse", done_out, 1'b0);
    end

    // R2: all-zero and all-ones operands
    run_one('0, '0, 64'h0, 1'b0, 56'h0, lat);
    check("R2 all zero", tag_out, 56'h0);
    run_one('1, '1, 64'h0, 1'b0, 56'h0, lat);
    check("R2 all ones", tag_out, ref_tag('1, '1, 64'h0));
    run_one('1, '0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 56'h0, lat);
    check("R1 mask only", tag_out, 56'hFF_FFFF_FFFF_FFFF);

    // R3: mask bits above 55 vanish
    run_one('0, '0, 64'hFF00_0000_0000_0000, 1'b0, 56'h0, lat);
    check("R3 truncation", tag_out, 56'h0);

    // R7: compare mode
    rand_line(q); rand_line(k); rng = next_rng(rng); m = rng;
    e = ref_tag(q, k, m);
    run_one(q, k, m, 1'b1, e, lat);
    check("R7 match equal", match_out, 1'b1);
    run_one(q, k, m, 1'b1, e ^ 56'h1, lat);
    check("R7 match differ", match_out, 1'b0);
    run_one(q, k, m, 1'b0, e, lat);
    check("R7 compare off", match_out, 1'b0);
    run_one(q, k, m, 1'b1, e ^ 56'h80_0000_0000_0000, lat);
    check("R7 top bit differ", match_out, 1'b0);

    // R9: outputs hold while idle and inputs change
    run_one(q, k, m, 1'b1, e, lat);
    @(negedge clk);
    line_in = '0; mask_in = '1; ref_tag_in = '0; cmp_mode_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 tag hold", tag_out, e);
    check("R9 match hold", match_out, 1'b1);

    // R6: start during a run is ignored
    rand_line(q); rand_line(k); rand_line(q2); rng = next_rng(rng); m = rng;
    @(negedge clk);
    line_in = q; hkey_in = k; mask_in = m; cmp_mode_in = 1'b0;
    start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    repeat (2) @(negedge clk);
    line_in = q2; mask_in = ~m; start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 done on time", done_out, 1'b1);
    check("R6 first result", tag_out, ref_tag(q, k, m));
    begin
      int extra = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (done_out) extra++;
      end
      check("R6 no extra done", extra, 0);
    end

    summary();
    $finish;
  end

endmodule